// File: doc/BRIEF.md
# Flash program/erase executor

This block performs the operations that change the contents of a small emulated parallel NOR flash array held in an on-chip synchronous byte RAM. A command sequencer hands it one request at a time. The request is either a program of 1, 2 or 4 bytes, an erase of the sector that holds an address, or an erase of the whole array. The executor applies the request to the RAM, keeps the flash status byte, and stays busy for the length of the operation. It then sends a single-cycle completion pulse back to the sequencer. The pulse also says whether the sequencer should go back to the bypass command stage or to plain read mode.

A program follows NOR semantics: each stored byte becomes the AND of its old value and the new byte, so a program can clear bits but never set them. An erase writes 0xFF across its range, one byte per cycle. It then waits for a parameterised busy delay, which for a chip erase is ten times the sector delay. When a read-only input is high at acceptance, the RAM is left untouched, but timing, status and completion behave exactly as they do for a writable array. A separate read port gives the sequencer access to the array contents.

Top module: `flash_pe_exec`

## Requirements
- R1: While reset is high, and in the first cycle after it, busy and done are 0 and the status byte is 0x00. A reset during an operation abandons that operation.
- R2: A program makes each target byte equal to the bitwise AND of its previous contents and the supplied byte.
- R3: Request encodings are fixed. For req_op, 0 is none, 1 is program, 2 is sector erase and 3 is chip erase. For req_size, 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes. Program byte k goes to address (req_addr+k) mod ARRAY_BYTES. With big_endian low, byte k is req_data[8k+7:8k]. With big_endian high, the most significant byte of the n-byte value goes to the lowest address.
- R4: A sector erase rounds req_addr down to a multiple of SECT_BYTES and writes 0xFF to all SECT_BYTES bytes from that point. No other byte changes.
- R5: A chip erase writes 0xFF to every byte of the array.
- R6: When read_only is 1 at acceptance, the array is unchanged. Busy length, status and the done outputs are the same as for a writable array.
- R7: From the cycle after an erase is accepted, the status byte reads 0x00. In the completion cycle, bit 7 of the status byte is inverted, so it reads 0x80.
- R8: From the cycle after a program is accepted, the status byte reads {~req_data[7], 7'h7F}. It keeps that value through completion.
- R9: A request is accepted when busy is 0 and req_valid is 1 with a nonzero op. Busy then stays high for a fixed number of cycles: 2n+1 for an n-byte program, SECT_BYTES+SECT_WAIT+1 for a sector erase, and ARRAY_BYTES+10*SECT_WAIT+1 for a chip erase. done is high only in the last busy cycle.
- R10: done_bypass is high only together with done. It equals the value the bypass input had at acceptance.
- R11: A request presented while busy is 1 is ignored and changes nothing in the array.
- R12: rd_data shows the array byte at the rd_addr value of the previous cycle. This holds whether or not the block is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe from the sequencer |
| req_op | input | 2 | Operation code (see R3) |
| req_addr | input | $clog2(ARRAY_BYTES) | Byte address of the request |
| req_data | input | 32 | Program data |
| req_size | input | 2 | Program size code |
| big_endian | input | 1 | Byte order for multi-byte programs |
| bypass | input | 1 | Sequencer is in bypass mode |
| read_only | input | 1 | Suppress array changes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Single-cycle completion pulse |
| done_bypass | output | 1 | Completion returns to the bypass stage |
| status | output | 8 | Flash status byte |
| rd_addr | input | $clog2(ARRAY_BYTES) | Array read address |
| rd_data | output | 8 | Array read data, one cycle latency |

## Verification
The bench builds the block with ARRAY_BYTES=256, SECT_BYTES=32 and SECT_WAIT=12. This gives eight sectors, a 45-cycle sector erase and a 377-cycle chip erase. With these sizes, every sector boundary, program wrap-around at the top address and full-array readback fit easily in one run. The small array also lets a chip erase finish between random program bursts. It makes a request injected during busy land in a different sector, where any wrongly accepted change would show up on readback.

// File: rtl/flash_pe_pkg.sv
package flash_pe_pkg;

    localparam int LANES = 4;
    localparam int DATA_W = 8 * LANES;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_PROG = 2'd1,
        OP_SECT = 2'd2,
        OP_CHIP = 2'd3
    } fpe_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRD,
        ST_PWR,
        ST_SWEEP,
        ST_WAIT,
        ST_FIN
    } fpe_state_e;

    typedef struct packed {
        fpe_op_e             op;
        logic [DATA_W-1:0]   data;
        logic [2:0]          nbytes;
        logic                be;
        logic                byp;
        logic                ro;
    } fpe_req_t;

    // size code to byte count: 0->1, 1->2, 2/3->4
    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // byte headed for offset idx inside an nb-byte program
    function automatic logic [7:0] lane_byte(input logic [DATA_W-1:0] d,
                                             input logic [2:0] nb,
                                             input logic [1:0] idx,
                                             input logic be);
        logic [2:0] k;
        k = be ? (nb - 3'd1 - {1'b0, idx}) : {1'b0, idx};
        return d[8*k[1:0] +: 8];
    endfunction

    function automatic logic [7:0] prog_status(input logic d7);
        return {~d7, 7'h7F};
    endfunction

endpackage

// File: rtl/flash_pe_ram.sv
module flash_pe_ram #(
    parameter int DEPTH = 1024,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] ra_addr,
    output logic [7:0]    ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [7:0]    rb_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        ra_data <= mem[ra_addr];
        rb_data <= mem[rb_addr];
    end
endmodule

// File: rtl/flash_pe_delay.sv
module flash_pe_delay #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/flash_pe_exec.sv
module flash_pe_exec
    import flash_pe_pkg::*;
#(
    parameter int ARRAY_BYTES = 1024,
    parameter int SECT_BYTES  = 128,
    parameter int SECT_WAIT   = 50,
    localparam int AW = $clog2(ARRAY_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [31:0]   req_data,
    input  logic [1:0]    req_size,
    input  logic          big_endian,
    input  logic          bypass,
    input  logic          read_only,
    output logic          busy,
    output logic          done,
    output logic          done_bypass,
    output logic [7:0]    status,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    localparam int SW        = $clog2(SECT_BYTES);
    localparam int CHIP_WAIT = 10 * SECT_WAIT;
    localparam int CW        = $clog2(CHIP_WAIT + 1);
    localparam logic [CW-1:0] SECT_LOAD = CW'(SECT_WAIT - 1);
    localparam logic [CW-1:0] CHIP_LOAD = CW'(CHIP_WAIT - 1);

    fpe_state_e    state_q;
    fpe_req_t      req_q;
    logic [AW-1:0] base_q;
    logic [AW-1:0] cur_q;
    logic [AW-1:0] last_q;
    logic [1:0]    idx_q;
    logic [7:0]    status_q;

    logic          accept;
    logic          wait_load;
    logic          wait_done;
    logic [CW-1:0] wait_val;
    logic [AW-1:0] prog_addr;
    logic          ram_we;
    logic [AW-1:0] ram_waddr;
    logic [7:0]    ram_wdata;
    logic [7:0]    ram_rdata;
    logic          prog_last;
    logic          sweep_last;

    assign accept     = (state_q == ST_IDLE) && req_valid && (fpe_op_e'(req_op) != OP_NONE);
    assign prog_addr  = base_q + AW'(idx_q);
    assign prog_last  = ({1'b0, idx_q} == (req_q.nbytes - 3'd1));
    assign sweep_last = (cur_q == last_q);
    assign wait_load  = (state_q == ST_SWEEP) && sweep_last;
    assign wait_val   = (req_q.op == OP_CHIP) ? CHIP_LOAD : SECT_LOAD;

    flash_pe_delay #(.CW(CW)) delay_i (
        .clk      (clk),
        .rst      (rst),
        .load     (wait_load),
        .load_val (wait_val),
        .expired  (wait_done)
    );

    always_comb begin
        ram_we    = 1'b0;
        ram_waddr = cur_q;
        ram_wdata = 8'hFF;
        if (state_q == ST_PWR) begin
            ram_we    = !req_q.ro;
            ram_waddr = prog_addr;
            ram_wdata = ram_rdata & lane_byte(req_q.data, req_q.nbytes, idx_q, req_q.be);
        end else if (state_q == ST_SWEEP) begin
            ram_we    = !req_q.ro;
        end
    end

    flash_pe_ram #(.DEPTH(ARRAY_BYTES)) ram_i (
        .clk     (clk),
        .we      (ram_we),
        .waddr   (ram_waddr),
        .wdata   (ram_wdata),
        .ra_addr (prog_addr),
        .ra_data (ram_rdata),
        .rb_addr (rd_addr),
        .rb_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            req_q    <= '0;
            base_q   <= '0;
            cur_q    <= '0;
            last_q   <= '0;
            idx_q    <= '0;
            status_q <= 8'h00;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    req_q.op     <= fpe_op_e'(req_op);
                    req_q.data   <= req_data;
                    req_q.nbytes <= size_bytes(req_size);
                    req_q.be     <= big_endian;
                    req_q.byp    <= bypass;
                    req_q.ro     <= read_only;
                    base_q       <= req_addr;
                    idx_q        <= '0;
                    case (fpe_op_e'(req_op))
                        OP_PROG: begin
                            status_q <= prog_status(req_data[7]);
                            state_q  <= ST_PRD;
                        end
                        OP_SECT: begin
                            status_q <= 8'h00;
                            cur_q    <= {req_addr[AW-1:SW], {SW{1'b0}}};
                            last_q   <= {req_addr[AW-1:SW], {SW{1'b1}}};
                            state_q  <= ST_SWEEP;
                        end
                        default: begin
                            status_q <= 8'h00;
                            cur_q    <= '0;
                            last_q   <= '1;
                            state_q  <= ST_SWEEP;
                        end
                    endcase
                end
                ST_PRD: state_q <= ST_PWR;
                ST_PWR: begin
                    if (prog_last) state_q <= ST_FIN;
                    else begin
                        idx_q   <= idx_q + 2'd1;
                        state_q <= ST_PRD;
                    end
                end
                ST_SWEEP: begin
                    cur_q <= cur_q + 1'b1;
                    if (sweep_last) state_q <= ST_WAIT;
                end
                ST_WAIT: if (wait_done) begin
                    status_q[7] <= ~status_q[7];
                    state_q     <= ST_FIN;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy        = (state_q != ST_IDLE);
    assign done        = (state_q == ST_FIN);
    assign done_bypass = (state_q == ST_FIN) && req_q.byp;
    assign status      = status_q;
endmodule

// File: rtl/flash_pe_exec_chk.sv
module flash_pe_exec_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic [1:0]  req_op,
    input logic [31:0] req_data,
    input logic        busy,
    input logic        done,
    input logic        done_bypass,
    input logic [7:0]  status
);
    // R9
    done_in_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R9
    done_last_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

    // R10
    bypass_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        done_bypass |-> done);

    // R7
    erase_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && req_op[1]) |=> (status == 8'h00));

    // R8
    prog_status_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid && req_op == 2'd1) |=> (status == {~$past(req_data[7]), 7'h7F}));

    // R7
    status_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && $past(busy)) |-> $stable(status));

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !done && status == 8'h00));
endmodule

bind flash_pe_exec flash_pe_exec_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_data    (req_data),
    .busy        (busy),
    .done        (done),
    .done_bypass (done_bypass),
    .status      (status)
);

// File: tb/flash_pe_exec_tb.sv
module flash_pe_exec_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ARR  = 256;
    localparam int SECT = 32;
    localparam int WT   = 12;
    localparam int AW   = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_data = '0;
    logic [1:0]    req_size = '0;
    logic          big_endian = 1'b0;
    logic          bypass = 1'b0;
    logic          read_only = 1'b0;
    logic          busy, done, done_bypass;
    logic [7:0]    status;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;

    logic [7:0] mdl [ARR];
    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_pe_exec #(.ARRAY_BYTES(ARR), .SECT_BYTES(SECT), .SECT_WAIT(WT)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .req_size(req_size),
        .big_endian(big_endian), .bypass(bypass), .read_only(read_only),
        .busy(busy), .done(done), .done_bypass(done_bypass), .status(status),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic int nbytes(input logic [1:0] sz);
        return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
    endfunction

    function automatic int exp_len(input logic [1:0] op, input logic [1:0] sz);
        if (op == 2'd1) return 2 * nbytes(sz) + 1;
        if (op == 2'd2) return SECT + WT + 1;
        return ARR + 10 * WT + 1;
    endfunction

    task automatic model_apply(input logic [1:0] op, input logic [AW-1:0] a,
                               input logic [31:0] d, input logic [1:0] sz, input bit be);
        int n;
        n = nbytes(sz);
        if (op == 2'd1) begin
            for (int k = 0; k < n; k++) begin
                logic [7:0] b;
                b = be ? d[8*(n-1-k) +: 8] : d[8*k +: 8];
                mdl[(int'(a) + k) % ARR] &= b;
            end
        end else if (op == 2'd2) begin
            int s;
            s = (int'(a) / SECT) * SECT;
            for (int k = 0; k < SECT; k++) mdl[s + k] = 8'hFF;
        end else begin
            for (int k = 0; k < ARR; k++) mdl[k] = 8'hFF;
        end
    endtask

    // runs one request; inject_addr >= 0 presents an extra program mid-busy
    task automatic run_op(input logic [1:0] op, input logic [AW-1:0] a, input logic [31:0] d,
                          input logic [1:0] sz, input bit be, input bit byp, input bit ro,
                          input int inject_addr, input string tag);
        logic [7:0] exp_st;
        int cnt, dones;
        bit st_ok, last_done;
        req_valid = 1'b1; req_op = op; req_addr = a; req_data = d; req_size = sz;
        big_endian = be; bypass = byp; read_only = ro;
        tick();
        req_valid = 1'b0;
        exp_st = (op == 2'd1) ? {~d[7], 7'h7F} : 8'h00;
        if (op == 2'd1) chk(status == exp_st, "R8 program status", status, exp_st);
        else            chk(status == exp_st, "R7 erase start status", status, exp_st);
        cnt = 0; dones = 0; st_ok = 1'b1; last_done = 1'b0;
        while (busy && cnt < 5000) begin
            cnt++;
            last_done = done;
            if (done) begin
                dones++;
                chk(done_bypass == byp, "R10 done_bypass", done_bypass, byp);
                if (op != 2'd1) chk(status == 8'h80, "R7 completion status", status, 8'h80);
                else            chk(status == exp_st, "R8 status at completion", status, exp_st);
            end else if (status != exp_st) st_ok = 1'b0;
            if (done_bypass && !done) st_ok = 1'b0;
            if (inject_addr >= 0 && cnt == 3) begin
                req_valid = 1'b1; req_op = 2'd1; req_addr = AW'(inject_addr);
                req_data = 32'h0; req_size = 2'd2; read_only = 1'b0;
            end else req_valid = 1'b0;
            tick();
        end
        req_valid = 1'b0;
        chk(cnt == exp_len(op, sz), {"R9 busy length ", tag}, cnt, exp_len(op, sz));
        chk(dones == 1 && last_done, "R9 single done in last busy cycle", dones, 1);
        chk(st_ok, "R7 R8 status held while busy", st_ok, 1);
        if (!ro) model_apply(op, a, d, sz, be);
    endtask

    task automatic check_array(input string tag);
        int mism, first;
        logic [7:0] got, want;
        mism = 0; first = -1; got = 0; want = 0;
        for (int i = 0; i < ARR; i++) begin
            rd_addr = AW'(i);
            tick();
            if (rd_data !== mdl[i]) begin
                if (first < 0) begin first = i; got = rd_data; want = mdl[i]; end
                mism++;
            end
        end
        chk(mism == 0, {tag, " R12 array readback"}, {first[15:0], 8'h0, got}, {first[15:0], 8'h0, want});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < ARR; i++) mdl[i] = 8'hFF;
        repeat (3) tick();
        chk(!busy && !done && status == 8'h00, "R1 state during reset", {busy, done, status}, 0);
        rst = 1'b0;
        tick();
        chk(!busy && !done && status == 8'h00, "R1 state after reset", {busy, done, status}, 0);

        // chip erase from unknown contents
        run_op(2'd3, 8'h00, 0, 0, 0, 0, 0, -1, "chip");
        check_array("R5 chip erase");

        // directed byte order
        run_op(2'd1, 8'h10, 32'h11223344, 2'd2, 1'b1, 1'b0, 1'b0, -1, "prog4 be");
        run_op(2'd1, 8'h20, 32'h11223344, 2'd2, 1'b0, 1'b1, 1'b0, -1, "prog4 le");
        run_op(2'd1, 8'h30, 32'h0000A55A, 2'd1, 1'b1, 1'b0, 1'b0, -1, "prog2 be");
        rd_addr = 8'h10; tick();
        chk(rd_data == 8'h11, "R3 big-endian MSB at lowest address", rd_data, 8'h11);
        rd_addr = 8'h20; tick();
        chk(rd_data == 8'h44, "R3 little-endian LSB at lowest address", rd_data, 8'h44);
        rd_addr = 8'h31; tick();
        chk(rd_data == 8'h5A, "R3 two-byte big-endian second byte", rd_data, 8'h5A);

        // AND semantics
        run_op(2'd1, 8'h40, 32'hF0, 2'd0, 1'b0, 1'b0, 1'b0, -1, "prog1");
        run_op(2'd1, 8'h40, 32'h3C, 2'd0, 1'b0, 1'b0, 1'b0, -1, "prog1");
        rd_addr = 8'h40; tick();
        chk(rd_data == 8'h30, "R2 program ANDs with old contents", rd_data, 8'h30);

        // wrap at top address
        run_op(2'd1, 8'hFE, 32'h12345678, 2'd2, 1'b0, 1'b0, 1'b0, -1, "prog wrap");

        // random programs
        for (int n = 0; n < 30; n++) begin
            logic [1:0] sz;
            sz = 2'($urandom_range(0, 3));
            run_op(2'd1, AW'($urandom), $urandom, sz, 1'($urandom), 1'($urandom), 1'b0, -1, "prog rand");
        end
        check_array("R2 R3 random programs");

        // sector erase on an unaligned address
        run_op(2'd2, 8'h45, 0, 0, 0, 1'b1, 1'b0, -1, "sector");
        check_array("R4 sector erase");

        // read-only program and erase
        run_op(2'd1, 8'h80, 32'h0, 2'd2, 1'b0, 1'b0, 1'b1, -1, "ro prog");
        run_op(2'd2, 8'hC3, 0, 0, 0, 1'b0, 1'b1, -1, "ro sector");
        run_op(2'd3, 8'h00, 0, 0, 0, 1'b1, 1'b1, -1, "ro chip");
        check_array("R6 read-only");

        // request during busy is ignored
        run_op(2'd2, 8'h05, 0, 0, 0, 1'b0, 1'b0, 8'hA0, "sector inject");
        check_array("R11 busy request ignored");

        // reset mid-operation
        req_valid = 1'b1; req_op = 2'd3; read_only = 1'b1; tick();
        req_valid = 1'b0; repeat (5) tick();
        rst = 1'b1; tick(); rst = 1'b0; tick();
        chk(!busy && !done && status == 8'h00, "R1 reset abandons operation", {busy, done, status}, 0);

        // final chip erase
        run_op(2'd3, 8'h77, 0, 0, 0, 1'b0, 1'b0, -1, "chip final");
        check_array("R5 final chip erase");

        summary();
    end
endmodule